// File: doc/BRIEF.md
# Array Data Address Generator

This unit forms the effective address for each load or store in a small array processor. A request carries a 2-bit mode, a base register value, a 32-bit address field, a 16-bit signed displacement, and three operands for circular buffers: an index, a stride and a buffer length. One cycle after the request is accepted, the unit presents the effective address. In circular mode it also presents the advanced index, with a write strobe, so the register file can store that index back.

There are four modes. An absolute address is taken straight from the instruction field. A base-plus-offset address adds the sign-extended displacement to the base. A register address uses the base value as it stands. A circular address is base plus index. In that mode the index then steps by the stride and wraps inside the buffer. The unit takes one request per clock. It has no storage other than its output register.

Top module: `dag_core`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `rsp_valid` and `rsp_idx_we` are 0. `req_ready` is 0 during reset and 1 from the first clock edge after reset onward.
- R2: Mode code 2'b00 (absolute) gives `rsp_addr` = `req_addr`.
- R3: Mode code 2'b01 (base plus offset) gives `rsp_addr` = `req_base` + the sign extension of `req_disp` (bit 15 is the sign), modulo 2^32.
- R4: Mode code 2'b10 (register) gives `rsp_addr` = `req_base`.
- R5: Mode code 2'b11 (circular) gives `rsp_addr` = `req_base` + `req_index`, modulo 2^32.
- R6: In circular mode, let s = (`req_index` + `req_stride`) mod 2^32. If `req_len` is nonzero and s >= `req_len` (unsigned), then `rsp_index` = s - `req_len`. Otherwise `rsp_index` = s.
- R7: In circular mode, a `req_len` of 0 disables the wrap, so `rsp_index` = s for any value of s.
- R8: `rsp_idx_we` is 1 only for a response to a circular-mode request. It is 0 for the other three modes and in idle cycles.
- R9: A request is accepted on any clock edge where `req_valid` and `req_ready` are both 1. Its response appears with `rsp_valid` = 1 after that edge. Back-to-back requests produce back-to-back responses.
- R10: If no request is accepted on an edge, `rsp_valid` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_mode | input | 2 | Addressing mode code |
| req_base | input | 32 | Base register value |
| req_addr | input | 32 | Absolute address field |
| req_disp | input | 16 | Signed displacement |
| req_index | input | 32 | Circular buffer index |
| req_stride | input | 32 | Index step for circular mode |
| req_len | input | 32 | Circular buffer length, 0 means no wrap |
| rsp_valid | output | 1 | Response present |
| rsp_addr | output | 32 | Effective address |
| rsp_index | output | 32 | Updated index for write-back |
| rsp_idx_we | output | 1 | Index write-back strobe |

## Verification
The bench targets the following corner cases. Each one names the failure it would expose.

- **Negative displacement and address overflow:** a design that zero-extends the displacement, or that keeps a carry bit, would produce an address far above the base.
- **Index lands exactly on the buffer length:** a design that compares with > instead of >= would output an index equal to the length instead of 0.
- **Buffer length of 0:** a design that wraps on a zero length would lose the plain index step.
- **Walk around a buffer, back-to-back with write-back:** a design with an extra register stage or a sticky write strobe would misalign responses or mark non-circular results for write-back.

// File: rtl/dag_pkg.sv
// Package: shared mode encoding for the data address generator.
// Assumes a 2-bit mode field in each request.
package dag_pkg;
    typedef enum logic [1:0] {
        AM_ABS  = 2'b00,
        AM_BOFS = 2'b01,
        AM_REG  = 2'b10,
        AM_CIRC = 2'b11
    } amode_e;
endpackage

// File: rtl/dag_ea_calc.sv
// Module: combinational effective-address selection for all four modes.
// Assumes DW <= AW or DW > AW; the displacement is sign-extended or truncated to AW.
module dag_ea_calc
    import dag_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 16
) (
    input  amode_e          mode,
    input  logic [AW-1:0]   base,
    input  logic [AW-1:0]   abs_addr,
    input  logic [AW-1:0]   idx,
    input  logic [DW-1:0]   disp,
    output logic [AW-1:0]   ea
);
    logic [AW-1:0] disp_ext;

    // Widen or narrow the displacement to the address width.
    generate
        if (DW < AW) begin : g_sext
            assign disp_ext = {{(AW-DW){disp[DW-1]}}, disp};
        end else begin : g_trunc
            assign disp_ext = disp[AW-1:0];
        end
    endgenerate

    // Pick the address term for the requested mode.
    always_comb begin
        unique case (mode)
            AM_ABS:  ea = abs_addr;
            AM_BOFS: ea = base + disp_ext;
            AM_REG:  ea = base;
            AM_CIRC: ea = base + idx;
            default: ea = abs_addr;
        endcase
    end
endmodule

// File: rtl/dag_circ_step.sv
// Module: advances a circular-buffer index by a stride with a single conditional wrap.
// Assumes index < len and stride <= len for a true modulo result; len == 0 disables wrap.
module dag_circ_step #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] idx,
    input  logic [AW-1:0] stride,
    input  logic [AW-1:0] len,
    output logic [AW-1:0] next_idx
);
    logic [AW-1:0] sum;
    logic          wrap;

    // Step the index, then subtract the length once if it was reached.
    always_comb begin
        sum      = idx + stride;
        wrap     = (len != '0) && (sum >= len);
        next_idx = wrap ? (sum - len) : sum;
    end
endmodule

// File: rtl/dag_resp_reg.sv
// Module: response register holding address, updated index and write strobe.
// Assumes a synchronous active-low reset; data fields hold when nothing loads.
module dag_resp_reg #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ea_d,
    input  logic [AW-1:0] idx_d,
    input  logic          we_d,
    output logic          valid_q,
    output logic [AW-1:0] ea_q,
    output logic [AW-1:0] idx_q,
    output logic          we_q
);
    // Control flags: cleared on reset, follow the accept strobe otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            we_q    <= 1'b0;
        end else begin
            valid_q <= load;
            we_q    <= load & we_d;
        end
    end

    // Data fields: capture on accept only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            ea_q  <= ea_d;
            idx_q <= idx_d;
        end
    end
endmodule

// File: rtl/dag_core.sv
// Module: top of the data address generator; one request per cycle, one-cycle latency.
// Assumes the consumer always takes the response (no output back-pressure).
module dag_core
    import dag_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_mode,
    input  logic [AW-1:0] req_base,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_disp,
    input  logic [AW-1:0] req_index,
    input  logic [AW-1:0] req_stride,
    input  logic [AW-1:0] req_len,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_addr,
    output logic [AW-1:0] rsp_index,
    output logic          rsp_idx_we
);
    amode_e        mode;
    logic          accept;
    logic [AW-1:0] ea_c;
    logic [AW-1:0] idx_c;

    assign mode   = amode_e'(req_mode);
    assign accept = req_valid & req_ready;

    // Ready rises one edge after reset and then stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) req_ready <= 1'b0;
        else        req_ready <= 1'b1;
    end

    dag_ea_calc #(.AW(AW), .DW(DW)) u_ea (
        .mode     (mode),
        .base     (req_base),
        .abs_addr (req_addr),
        .idx      (req_index),
        .disp     (req_disp),
        .ea       (ea_c)
    );

    dag_circ_step #(.AW(AW)) u_step (
        .idx      (req_index),
        .stride   (req_stride),
        .len      (req_len),
        .next_idx (idx_c)
    );

    dag_resp_reg #(.AW(AW)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .ea_d    (ea_c),
        .idx_d   (idx_c),
        .we_d    (mode == AM_CIRC),
        .valid_q (rsp_valid),
        .ea_q    (rsp_addr),
        .idx_q   (rsp_index),
        .we_q    (rsp_idx_we)
    );
endmodule

// File: rtl/dag_checker.sv
// Module: protocol and mode checks for dag_core, attached by bind.
// Assumes it sees only the top-level ports.
module dag_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [1:0]    req_mode,
    input logic [AW-1:0] req_base,
    input logic [AW-1:0] req_addr,
    input logic [AW-1:0] req_index,
    input logic [AW-1:0] req_stride,
    input logic [AW-1:0] req_len,
    input logic          rsp_valid,
    input logic [AW-1:0] rsp_addr,
    input logic [AW-1:0] rsp_index,
    input logic          rsp_idx_we
);
    logic acc;
    assign acc = req_valid & req_ready;

    // R9: an accepted request yields a response on the next edge.
    assert_resp_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);

    // R10: an edge without acceptance leaves no response.
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid);

    // R8: only circular requests raise the write strobe.
    assert_we_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_mode != 2'b11) |=> !rsp_idx_we);

    // R8: the strobe never appears without a response.
    assert_we_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_idx_we |-> rsp_valid);

    // R2: absolute mode passes the address field through.
    assert_abs_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_mode == 2'b00) |=> rsp_addr == $past(req_addr));

    // R4: register mode passes the base through.
    assert_reg_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_mode == 2'b10) |=> rsp_addr == $past(req_base));

    // R6: in-range operands keep the updated index inside the buffer.
    assert_wrap_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_mode == 2'b11 && req_len != '0 && req_index < req_len
         && req_stride <= req_len) |=> rsp_index < $past(req_len));
endmodule

bind dag_core dag_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_mode   (req_mode),
    .req_base   (req_base),
    .req_addr   (req_addr),
    .req_index  (req_index),
    .req_stride (req_stride),
    .req_len    (req_len),
    .rsp_valid  (rsp_valid),
    .rsp_addr   (rsp_addr),
    .rsp_index  (rsp_index),
    .rsp_idx_we (rsp_idx_we)
);

// File: tb/sim_dag_core.sv
`timescale 1ns/1ps
module sim_dag_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_mode = 2'b00;
    logic [31:0] req_base = '0, req_addr = '0, req_index = '0, req_stride = '0, req_len = '0;
    logic [15:0] req_disp = '0;
    logic        rsp_valid, rsp_idx_we;
    logic [31:0] rsp_addr, rsp_index;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dag_core u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_base(req_base), .req_addr(req_addr), .req_disp(req_disp),
        .req_index(req_index), .req_stride(req_stride), .req_len(req_len),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_index(rsp_index),
        .rsp_idx_we(rsp_idx_we)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] step_ref(input logic [31:0] i, s, l);
        logic [31:0] t;
        t = i + s;
        if (l != 0 && t >= l) t = t - l;
        return t;
    endfunction

    // Drive one request at the falling edge, check after the accepting edge.
    task automatic issue(input string tag, input logic [1:0] m, input logic [31:0] b,
                         input logic [31:0] a, input logic [15:0] d, input logic [31:0] i,
                         input logic [31:0] s, input logic [31:0] l);
        logic [31:0] ea;
        case (m)
            2'b00: ea = a;
            2'b01: ea = b + {{16{d[15]}}, d};
            2'b10: ea = b;
            default: ea = b + i;
        endcase
        @(negedge clk);
        req_valid = 1; req_mode = m; req_base = b; req_addr = a; req_disp = d;
        req_index = i; req_stride = s; req_len = l;
        @(posedge clk); #1;
        check({tag, " R9 valid"}, {31'b0, rsp_valid}, 32'd1);
        check({tag, " addr"}, rsp_addr, ea);
        check({tag, " R8 we"}, {31'b0, rsp_idx_we}, {31'b0, m == 2'b11});
        if (m == 2'b11) check({tag, " index"}, rsp_index, step_ref(i, s, l));
        req_valid = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 valid in reset", {31'b0, rsp_valid}, 0);
        check("R1 we in reset", {31'b0, rsp_idx_we}, 0);
        check("R1 ready in reset", {31'b0, req_ready}, 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 valid after reset", {31'b0, rsp_valid}, 0);
        check("R1 ready after reset", {31'b0, req_ready}, 1);
    endtask

    task automatic t_plain_modes();
        issue("R2 abs a", 2'b00, 32'h1111_0000, 32'hDEAD_BEEF, 16'h0004, 0, 0, 0);
        issue("R2 abs b", 2'b00, 32'h0, 32'h0000_0010, 16'hFFFF, 5, 1, 8);
        issue("R3 disp pos", 2'b01, 32'h0000_1000, 0, 16'h0024, 0, 0, 0);
        issue("R3 disp neg", 2'b01, 32'h0000_1000, 0, 16'hFFF0, 0, 0, 0);
        issue("R3 wrap 2^32", 2'b01, 32'hFFFF_FFF0, 0, 16'h0020, 0, 0, 0);
        issue("R4 reg", 2'b10, 32'hCAFE_0040, 32'h5, 16'h7FFF, 3, 3, 4);
    endtask

    task automatic t_circular();
        issue("R5 R6 no wrap", 2'b11, 32'h2000, 0, 0, 32'd3, 32'd2, 32'd8);
        issue("R6 wrap", 2'b11, 32'h2000, 0, 0, 32'd6, 32'd4, 32'd8);
        issue("R6 exact len", 2'b11, 32'h2000, 0, 0, 32'd5, 32'd3, 32'd8);
        issue("R7 len zero", 2'b11, 32'h3000, 0, 0, 32'd100, 32'd50, 32'd0);
        issue("R5 addr wrap", 2'b11, 32'hFFFF_FFFC, 0, 0, 32'd8, 32'd1, 32'd16);
    endtask

    task automatic t_idle();
        @(negedge clk); req_valid = 0;
        @(posedge clk); #1;
        check("R10 idle valid", {31'b0, rsp_valid}, 0);
        check("R8 idle we", {31'b0, rsp_idx_we}, 0);
    endtask

    // Back-to-back walk around a buffer of 5 with stride 2, feeding the index back.
    task automatic t_walk();
        logic [31:0] idx = 0;
        @(negedge clk);
        req_valid = 1; req_mode = 2'b11; req_base = 32'h4000;
        req_stride = 2; req_len = 5;
        for (int k = 0; k < 7; k++) begin
            req_index = idx;
            @(posedge clk); #1;
            check("R9 b2b valid", {31'b0, rsp_valid}, 1);
            check("R5 walk addr", rsp_addr, 32'h4000 + idx);
            check("R6 walk index", rsp_index, (idx + 2) % 5);
            idx = rsp_index;
        end
        req_mode = 2'b01; req_disp = 16'h0008;
        @(posedge clk); #1;
        check("R8 b2b we drop", {31'b0, rsp_idx_we}, 0);
        check("R3 b2b addr", rsp_addr, 32'h4008);
        req_valid = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_plain_modes();
        t_idle();
        t_circular();
        t_walk();
        t_idle();
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule